// File: doc/BRIEF.md
# ADC Periodic Trigger Timer

This block paces an analog-to-digital conversion queue. A counter advances once per clock and, when it reaches a terminal count chosen by a period-select field, emits a one-clock trigger pulse. A two-bit mode field picks the behaviour. Disabled mode holds the counter at zero. Periodic mode emits a trigger train. Interval mode emits one trigger and then waits. Software sets the mode and the period through a single write port that restarts the counter.

Two system conditions override the counter. The stop condition clears the control state, and the counter stays at zero until software writes a valid mode again. The debug condition freezes the counter at zero. If a conversion is running when debug is requested, the freeze waits until that conversion ends. Otherwise the freeze takes effect at once. When debug ends, counting restarts from zero rather than resuming. The counter value is exposed so that tests can observe it.

Top module: `adc_trig_timer`

## Requirements
- R1: After reset, `count` is 0, `trig` is low and the mode is disabled.
- R2: A write (`wr_en` high) loads `wr_mode` and `wr_psel` and sets `count` to 0. In a running mode, `count` then rises by one on every clock.
- R3: In periodic mode (`wr_mode` = 2'b01), `trig` is high for exactly one clock every 2^(BASE_EXP+psel) clocks, and `count` reads 0 in the cycle the pulse is high.
- R4: In interval mode (`wr_mode` = 2'b10), exactly one pulse is produced, 2^(BASE_EXP+psel) clocks after the write. `count` then stays at 0 with no further pulse until the next write.
- R5: Mode codes 2'b00 and 2'b11 keep `count` at 0 and `trig` low.
- R6: While `stop_req` is high, `count` is 0, the mode and period are cleared and writes are ignored. After `stop_req` falls, `count` stays at 0.
- R7: A valid mode written after a stop restarts counting from 0.
- R8: When `dbg_req` is high and `conv_busy` is low, `count` is 0 from the next clock and is held there, with no pulse.
- R9: When `dbg_req` rises while `conv_busy` is high, counting continues until `conv_busy` falls. From the next clock, `count` is held at 0 for as long as `dbg_req` stays high.
- R10: When `dbg_req` falls, counting restarts from 0: k clocks later, `count` equals k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | Stop condition; clears control state |
| dbg_req | input | 1 | Debug freeze request |
| conv_busy | input | 1 | A triggered conversion is in progress |
| wr_en | input | 1 | Control write strobe |
| wr_mode | input | 2 | 00 disabled, 01 periodic, 10 interval, 11 invalid |
| wr_psel | input | SEL_W | Period select n; terminal period 2^(BASE_EXP+n) |
| trig | output | 1 | One-clock trigger pulse |
| count | output | BASE_EXP+2^SEL_W-1 | Counter value for test |

## Verification
The bench builds the block with BASE_EXP = 2 and SEL_W = 4. This shrinks the shortest period to 4 clocks, so period selects 0 to 3 (periods of 4 to 32 clocks) can be checked over several pulses within a short run. The counter width stays at its full derived size of 17 bits. With periods this short, the bench can also watch an interval trigger, a stop in the middle of a count, and both debug freeze paths cycle by cycle.

// File: rtl/adc_trig_timer.sv
module adc_trig_timer #(
  parameter int BASE_EXP = 7,
  parameter int SEL_W    = 4,
  localparam int CNT_W   = BASE_EXP + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             dbg_req,
  input  logic             conv_busy,
  input  logic             wr_en,
  input  logic [1:0]       wr_mode,
  input  logic [SEL_W-1:0] wr_psel,
  output logic             trig,
  output logic [CNT_W-1:0] count
);
  localparam logic [1:0] MODE_PER = 2'b01;
  localparam logic [1:0] MODE_INT = 2'b10;

  logic [1:0]       mode_q;
  logic [SEL_W-1:0] psel_q;
  logic             done_q, frz_q, trig_q;
  logic [CNT_W-1:0] cnt_q;

  wire             mode_ok = (mode_q == MODE_PER) || (mode_q == MODE_INT);
  wire             frz_now = dbg_req & (frz_q | ~conv_busy);
  wire [SEL_W-1:0] inv_sel = ~psel_q;
  wire [CNT_W-1:0] tc      = {CNT_W{1'b1}} >> inv_sel;
  wire             run     = mode_ok & ~stop_req & ~frz_now & ~done_q;
  wire             hit     = run & (cnt_q == tc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      psel_q <= '0;
      done_q <= 1'b0;
      frz_q  <= 1'b0;
      trig_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      frz_q  <= frz_now;
      trig_q <= hit & ~wr_en;
      if (stop_req) begin
        mode_q <= '0;
        psel_q <= '0;
        done_q <= 1'b0;
        cnt_q  <= '0;
      end else if (wr_en) begin
        mode_q <= wr_mode;
        psel_q <= wr_psel;
        done_q <= 1'b0;
        cnt_q  <= '0;
      end else if (!run) begin
        cnt_q  <= '0;
      end else if (hit) begin
        cnt_q  <= '0;
        done_q <= (mode_q == MODE_INT);
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign trig  = trig_q;
  assign count = cnt_q;
endmodule

// File: rtl/adc_trig_timer_chk.sv
module adc_trig_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_req,
  input logic             dbg_req,
  input logic             conv_busy,
  input logic             wr_en,
  input logic             trig,
  input logic [CNT_W-1:0] count,
  input logic [1:0]       mode_q,
  input logic             frz_q
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (count == '0 && !trig)); // R1
  AST_TRIG_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) trig |-> count == '0); // R3
  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) trig |=> !trig); // R3
  AST_IDLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b01 && mode_q != 2'b10 && !wr_en) |=> (count == '0 && !trig)); // R5
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (count == '0 && mode_q == 2'b00 && !trig)); // R6
  AST_DBG_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && !conv_busy) |=> (count == '0 && !trig)); // R8
  AST_DBG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && frz_q) |=> (count == '0 && !trig)); // R9
endmodule

bind adc_trig_timer adc_trig_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .dbg_req(dbg_req),
  .conv_busy(conv_busy), .wr_en(wr_en), .trig(trig), .count(count),
  .mode_q(mode_q), .frz_q(frz_q)
);

// File: tb/adc_trig_timer_bench.sv
module adc_trig_timer_bench;
  localparam int BASE_EXP = 2;
  localparam int SEL_W    = 4;
  localparam int CNT_W    = BASE_EXP + (1 << SEL_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stop_req = 1'b0, dbg_req = 1'b0, conv_busy = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_mode = 2'b00;
  logic [SEL_W-1:0] wr_psel = '0;
  logic trig;
  logic [CNT_W-1:0] count;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_trig_timer #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) u_adc_trig_timer (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .dbg_req(dbg_req),
    .conv_busy(conv_busy), .wr_en(wr_en), .wr_mode(wr_mode), .wr_psel(wr_psel),
    .trig(trig), .count(count));

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] m, input int ps);
    wr_en = 1'b1; wr_mode = m; wr_psel = SEL_W'(ps);
    tick();
    wr_en = 1'b0;
  endtask

  // returns clocks until trig seen (limit+1 if never)
  task automatic wait_trig(input int limit, output int n);
    n = 0;
    while (!trig && n <= limit) begin
      tick();
      n++;
    end
  endtask

  task automatic t_reset();
    chk(count == 0, "R1 count", count, 0);
    chk(trig == 0, "R1 trig", trig, 0);
    tick(5);
    chk(count == 0 && !trig, "R1 disabled after reset", count, 0);
  endtask

  task automatic t_count();
    wr(2'b01, 3);
    chk(count == 0, "R2 write loads zero", count, 0);
    tick(7);
    chk(count == 7, "R2 increment", count, 7);
    wr(2'b01, 3);
    chk(count == 0, "R2 rewrite restarts", count, 0);
  endtask

  task automatic t_periodic(input int ps);
    int n, exp;
    exp = 1 << (BASE_EXP + ps);
    wr(2'b01, ps);
    wait_trig(exp + 2, n);
    chk(n == exp, "R3 first period", n, exp);
    chk(count == 0, "R3 count zero at pulse", count, 0);
    for (int k = 0; k < 2; k++) begin
      tick();
      chk(!trig, "R3 pulse width", trig, 0);
      wait_trig(exp + 2, n);
      chk(n + 1 == exp, "R3 repeat period", n + 1, exp);
    end
  endtask

  task automatic t_interval();
    int n, hits;
    wr(2'b10, 1);
    wait_trig(10, n);
    chk(n == 8, "R4 interval first", n, 8);
    hits = 0;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (trig || count != 0) hits++;
    end
    chk(hits == 0, "R4 no further activity", hits, 0);
    wr(2'b10, 0);
    wait_trig(6, n);
    chk(n == 4, "R4 rewrite rearms", n, 4);
  endtask

  task automatic t_invalid();
    int bad;
    wr(2'b11, 0);
    bad = 0;
    for (int i = 0; i < 20; i++) begin tick(); if (trig || count != 0) bad++; end
    chk(bad == 0, "R5 mode 11 idle", bad, 0);
    wr(2'b00, 0);
    bad = 0;
    for (int i = 0; i < 20; i++) begin tick(); if (trig || count != 0) bad++; end
    chk(bad == 0, "R5 mode 00 idle", bad, 0);
  endtask

  task automatic t_stop();
    int bad;
    wr(2'b01, 3);
    tick(10);
    stop_req = 1'b1;
    tick();
    chk(count == 0, "R6 stop clears", count, 0);
    wr(2'b01, 0);
    stop_req = 1'b0;
    bad = 0;
    for (int i = 0; i < 30; i++) begin tick(); if (trig || count != 0) bad++; end
    chk(bad == 0, "R6 held after stop", bad, 0);
    wr(2'b01, 2);
    tick(5);
    chk(count == 5, "R7 restart after stop", count, 5);
  endtask

  task automatic t_dbg_idle();
    int bad;
    wr(2'b01, 3);
    tick(6);
    dbg_req = 1'b1;
    tick();
    chk(count == 0, "R8 immediate freeze", count, 0);
    bad = 0;
    for (int i = 0; i < 40; i++) begin tick(); if (trig || count != 0) bad++; end
    chk(bad == 0, "R8 held in debug", bad, 0);
    dbg_req = 1'b0;
    tick(3);
    chk(count == 3, "R10 restart from zero", count, 3);
  endtask

  task automatic t_dbg_busy();
    int bad;
    wr(2'b01, 3);
    tick(4);
    conv_busy = 1'b1;
    dbg_req = 1'b1;
    tick(3);
    chk(count == 7, "R9 counts while busy", count, 7);
    conv_busy = 1'b0;
    tick();
    chk(count == 0, "R9 freeze after busy ends", count, 0);
    conv_busy = 1'b1;
    bad = 0;
    for (int i = 0; i < 10; i++) begin tick(); if (trig || count != 0) bad++; end
    chk(bad == 0, "R9 stays frozen", bad, 0);
    conv_busy = 1'b0;
    dbg_req = 1'b0;
    tick(6);
    chk(count == 6, "R10 restart after busy freeze", count, 6);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_count();
    t_periodic(0);
    t_periodic(1);
    t_periodic(3);
    t_interval();
    t_invalid();
    t_stop();
    t_dbg_idle();
    t_dbg_busy();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule